// File: doc/BRIEF.md
# Host-to-PCI Address Window Bridge

This block sits between a synchronous CPU-side request/response bus and a simple PCI-style downstream request port. It watches every CPU access. When the address falls into one of three fixed windows, the block claims it: a control window, an I/O window or a memory window. Otherwise it leaves the access alone.

Accesses in the memory and I/O windows go downstream. The offset into the window is rebased onto a programmable base register, and the access size passes through unchanged. Accesses in the control window are handled locally. That window holds:
- a 256-byte configuration image, read and written as 32-bit words;
- a configuration-address register and two write-only window base registers;
- a data port, which turns each access into a 32-bit configuration cycle on the downstream port at the address held in the configuration-address register.

Only one transaction is in flight at a time. A CPU request is taken only while the bridge is idle. Forwarded accesses wait for the downstream acknowledge before the CPU acknowledge is returned.

Size encoding on both sides: 0 = byte, 1 = halfword, 2 = word. Downstream space encoding: 0 = configuration, 1 = memory, 2 = I/O.

Top module: `hostwin_bridge`

## Requirements
- R1: The control window is 0x1E200000 up to 0x1E200223, the I/O window is 0x1E240000 up to 0x1E27FFFF and the memory window is 0xFD000000 up to 0xFDFFFFFF. A request to any other address raises neither `dn_req` nor `cpu_ack`.
- R2: Word accesses at aligned control offsets 0x000 to 0x0FC read and write the configuration image, one 32-bit word per offset, with byte 0 in bits 7:0.
- R3: After reset, configuration word 0 reads 0x350E1054 and word 1 reads 0x02900080.
- R4: Control offset 0x1C0 is a readable and writable configuration-address register. Offset 0x1C4 (memory base) and offset 0x1C8 (I/O base) accept writes but read as zero. Every other control offset reads as zero and ignores writes.
- R5: A word access at control offset 0x220 issues a downstream request with space 0, size 2, the configuration-address register as address, and the same direction as the CPU access. A read returns the downstream data.
- R6: A byte or halfword access to the control window is acknowledged, but a write changes nothing and a read returns zero.
- R7: A memory-window access goes downstream with space 1, the CPU size, the CPU write data, and address (CPU address − 0xFD000000 + memory base).
- R8: An I/O-window access goes downstream with space 2, the CPU size, and address (CPU address − 0x1E240000 + I/O base).
- R9: A forwarded request holds `dn_req` and its fields until `dn_ack`. `cpu_ack` rises the cycle after `dn_ack` and carries `dn_rdata` for reads. CPU requests made while a transaction is pending are ignored.
- R10: A local control access is acknowledged the cycle after the request is taken. `cpu_ack` is a single-cycle pulse.
- R11: Reset clears every register except configuration words 0 and 1. Both base registers start at zero, and `cpu_ack` and `dn_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request strobe, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size (0 byte, 1 half, 2 word) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| dn_req | output | 1 | Downstream request, held until `dn_ack` |
| dn_we | output | 1 | Downstream direction |
| dn_space | output | 2 | 0 config, 1 memory, 2 I/O |
| dn_addr | output | 32 | Translated downstream address |
| dn_size | output | 2 | Downstream access size |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |

## Verification
Two events can fall on the same clock edge:
- the downstream acknowledge that ends a pending transaction;
- a fresh CPU request.

The bench provokes this by raising a control-register write for one cycle exactly when its responder returns `dn_ack` for an outstanding memory read. It then judges the outcome two ways. First, the per-cycle reference model requires exactly one `cpu_ack`, carrying the downstream data. Second, a read of the configuration-address register afterwards must still return its earlier value, which shows that the stray write was dropped.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

   typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} hwb_size_e;
   typedef enum logic [1:0] {SP_CFG = 2'd0, SP_MEM = 2'd1, SP_IO = 2'd2} hwb_space_e;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} hwb_state_e;
   typedef enum logic [1:0] {WIN_NONE, WIN_REG, WIN_IO, WIN_MEM} hwb_win_e;

   // control-window offsets; the data port and register slots are decoded exactly
   localparam int unsigned OFF_CADDR  = 'h1C0;
   localparam int unsigned OFF_MBASE  = 'h1C4;
   localparam int unsigned OFF_IOBASE = 'h1C8;
   localparam int unsigned OFF_PORT   = 'h220;

endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
   import hwb_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] REG_BASE = 32'h1E20_0000,
   parameter logic [AW-1:0] REG_SPAN = 32'h0000_0224,
   parameter logic [AW-1:0] IO_BASE  = 32'h1E24_0000,
   parameter logic [AW-1:0] IO_SPAN  = 32'h0004_0000,
   parameter logic [AW-1:0] MEM_BASE = 32'hFD00_0000,
   parameter logic [AW-1:0] MEM_SPAN = 32'h0100_0000
) (
   input  logic [AW-1:0] addr,
   output hwb_win_e      win,
   output logic [AW-1:0] off
);

   localparam int NWIN = 3;
   localparam logic [AW-1:0] BASES [NWIN] = '{REG_BASE, IO_BASE, MEM_BASE};
   localparam logic [AW-1:0] SPANS [NWIN] = '{REG_SPAN, IO_SPAN, MEM_SPAN};

   logic [AW-1:0]   rel [NWIN];
   logic [NWIN-1:0] hit;

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         initial begin
            assert (SPANS[w] != '0 &&
                    ({1'b0, BASES[w]} + {1'b0, SPANS[w]}) <= {1'b1, {AW{1'b0}}})
               else $error("hwb_decode: window %0d span invalid", w);
         end
         assign rel[w] = addr - BASES[w];
         assign hit[w] = (addr >= BASES[w]) && (rel[w] < SPANS[w]);
      end
   endgenerate

   always_comb begin
      win = WIN_NONE;
      off = '0;
      if (hit[0]) begin
         win = WIN_REG;
         off = rel[0];
      end else if (hit[1]) begin
         win = WIN_IO;
         off = rel[1];
      end else if (hit[2]) begin
         win = WIN_MEM;
         off = rel[2];
      end
   end

endmodule

// File: rtl/hwb_regfile.sv
module hwb_regfile
   import hwb_pkg::*;
#(
   parameter int            AW        = 32,
   parameter int            DW        = 32,
   parameter int            CFG_WORDS = 64,
   parameter logic [DW-1:0] ID_WORD   = 32'h350E_1054,
   parameter logic [DW-1:0] CMD_WORD  = 32'h0290_0080
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] caddr,
   output logic [AW-1:0] mbase,
   output logic [AW-1:0] iobase
);

   localparam int            IDXW    = $clog2(CFG_WORDS);
   localparam logic [AW-1:0] CFG_END = AW'(CFG_WORDS * 4);

   initial begin
      assert (DW == 32) else $error("hwb_regfile: data width must be 32");
      assert (CFG_WORDS * 4 <= int'(OFF_CADDR) && (1 << IDXW) == CFG_WORDS)
         else $error("hwb_regfile: image overlaps register slots or is not a power of two");
      assert (AW >= 12) else $error("hwb_regfile: address too narrow");
   end

   logic [DW-1:0]   cfg_q [CFG_WORDS];
   logic            cfg_hit;
   logic [IDXW-1:0] idx;

   assign cfg_hit = (off < CFG_END) && (off[1:0] == 2'b00);
   assign idx     = off[IDXW+1:2];

   generate
      for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
         localparam logic [DW-1:0] INIT = (w == 0) ? ID_WORD :
                                          (w == 1) ? CMD_WORD : '0;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cfg_q[w] <= INIT;
            else if (wr_en && cfg_hit && idx == IDXW'(w))
               cfg_q[w] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         caddr  <= '0;
         mbase  <= '0;
         iobase <= '0;
      end else if (wr_en) begin
         if (off == AW'(OFF_CADDR))  caddr  <= AW'(wdata);
         if (off == AW'(OFF_MBASE))  mbase  <= AW'(wdata);
         if (off == AW'(OFF_IOBASE)) iobase <= AW'(wdata);
      end
   end

   always_comb begin
      if (cfg_hit)
         rdata = cfg_q[idx];
      else if (off == AW'(OFF_CADDR))
         rdata = DW'(caddr);
      else
         rdata = '0;
   end

endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge
   import hwb_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CFG_WORDS = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [31:0]   cpu_addr,
   input  logic [1:0]    cpu_size,
   input  logic [31:0]   cpu_wdata,
   output logic          cpu_ack,
   output logic [31:0]   cpu_rdata,
   output logic          dn_req,
   output logic          dn_we,
   output logic [1:0]    dn_space,
   output logic [31:0]   dn_addr,
   output logic [1:0]    dn_size,
   output logic [31:0]   dn_wdata,
   input  logic          dn_ack,
   input  logic [31:0]   dn_rdata
);

   initial begin
      assert (AW == 32 && DW == 32) else $error("hostwin_bridge: port widths fixed at 32");
   end

   hwb_win_e      win;
   logic [AW-1:0] off;
   logic [DW-1:0] reg_rdata;
   logic [AW-1:0] caddr, mbase, iobase;
   hwb_state_e    st_q;
   logic          is_word, accept, reg_ok, reg_wr, fwd;
   logic [AW-1:0] fwd_addr;
   hwb_space_e    fwd_space;
   logic [DW-1:0] rdata_q;

   hwb_decode #(.AW(AW)) u_decode (
      .addr (cpu_addr),
      .win  (win),
      .off  (off)
   );

   assign is_word = (cpu_size == SZ_WORD);
   assign accept  = cpu_req && (st_q == ST_IDLE) && (win != WIN_NONE);
   assign reg_ok  = (win == WIN_REG) && is_word;
   assign reg_wr  = accept && reg_ok && cpu_we;

   hwb_regfile #(.AW(AW), .DW(DW), .CFG_WORDS(CFG_WORDS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .off    (off),
      .wdata  (cpu_wdata),
      .rdata  (reg_rdata),
      .caddr  (caddr),
      .mbase  (mbase),
      .iobase (iobase)
   );

   // rebase the window offset onto the selected downstream base
   always_comb begin
      fwd       = 1'b1;
      fwd_space = SP_MEM;
      fwd_addr  = off + mbase;
      case (win)
         WIN_MEM: ;
         WIN_IO: begin
            fwd_space = SP_IO;
            fwd_addr  = off + iobase;
         end
         WIN_REG: begin
            fwd       = reg_ok && (off == AW'(OFF_PORT));
            fwd_space = SP_CFG;
            fwd_addr  = caddr;
         end
         default: fwd = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         rdata_q  <= '0;
         dn_req   <= 1'b0;
         dn_we    <= 1'b0;
         dn_space <= 2'd0;
         dn_addr  <= '0;
         dn_size  <= 2'd0;
         dn_wdata <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (fwd) begin
                     st_q     <= ST_WAIT;
                     dn_req   <= 1'b1;
                     dn_we    <= cpu_we;
                     dn_space <= fwd_space;
                     dn_addr  <= fwd_addr;
                     dn_size  <= cpu_size;
                     dn_wdata <= cpu_wdata;
                  end else begin
                     st_q    <= ST_DONE;
                     rdata_q <= (reg_ok && !cpu_we) ? reg_rdata : '0;
                  end
               end
            end
            ST_WAIT: begin
               if (dn_ack) begin
                  st_q    <= ST_DONE;
                  dn_req  <= 1'b0;
                  rdata_q <= dn_we ? '0 : dn_rdata;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ack   = (st_q == ST_DONE);
   assign cpu_rdata = rdata_q;

endmodule

// File: rtl/hwb_chk.sv
module hwb_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req,
   input logic        cpu_ack,
   input logic        dn_req,
   input logic        dn_ack,
   input logic [31:0] dn_addr,
   input logic [1:0]  dn_space,
   input logic [1:0]  dn_size
);

   // R9
   dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_space));

   // R9
   ack_follows_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_ack |=> cpu_ack && !dn_req);

   // R9
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !dn_req);

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R5
   cfg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_space == 2'd0 |-> dn_size == 2'd2);

   // R1
   req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_req) |-> $past(cpu_req));

endmodule

bind hostwin_bridge hwb_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_ack  (cpu_ack),
   .dn_req   (dn_req),
   .dn_ack   (dn_ack),
   .dn_addr  (dn_addr),
   .dn_space (dn_space),
   .dn_size  (dn_size)
);

// File: tb/hostwin_bridge_tb.sv
`timescale 1ns/1ps
module hostwin_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [1:0]  cpu_size = 2'd2;
   logic        cpu_ack, dn_req, dn_we;
   logic [31:0] cpu_rdata, dn_addr, dn_wdata;
   logic [1:0]  dn_space, dn_size;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   always #10 clk = ~clk;

   hostwin_bridge u_dut (.*);

   int    n_chk = 0, n_fail = 0;
   bit    finished = 0;
   string cur_tag = "R11";

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_state;
   logic [31:0] m_cfg [64];
   logic [31:0] m_par, m_mbr, m_iobr, m_rdata, m_daddr, m_dwdata;
   logic [1:0]  m_dspace, m_dsize;
   logic        m_rd, m_dwe;

   task automatic model_accept();
      logic [31:0] a, o;
      bit hit, fwd;
      a = cpu_addr; hit = 0; fwd = 0;
      m_rd = !cpu_we; m_dwe = cpu_we; m_dwdata = cpu_wdata; m_dsize = cpu_size;
      if (a >= 32'h1E200000 && a < 32'h1E200224) begin
         hit = 1; o = a - 32'h1E200000; m_rdata = 0;
         if (cpu_size == 2'd2) begin
            if (o == 32'h220) begin
               fwd = 1; m_dspace = 0; m_daddr = m_par;
            end else if (cpu_we) begin
               if (o < 32'h100 && o[1:0] == 0) m_cfg[o >> 2] = cpu_wdata;
               else if (o == 32'h1C0) m_par = cpu_wdata;
               else if (o == 32'h1C4) m_mbr = cpu_wdata;
               else if (o == 32'h1C8) m_iobr = cpu_wdata;
            end else if (o < 32'h100 && o[1:0] == 0) m_rdata = m_cfg[o >> 2];
            else if (o == 32'h1C0) m_rdata = m_par;
         end
      end else if (a >= 32'h1E240000 && a < 32'h1E280000) begin
         hit = 1; fwd = 1; m_dspace = 2; m_daddr = a - 32'h1E240000 + m_iobr;
      end else if (a >= 32'hFD000000 && a < 32'hFE000000) begin
         hit = 1; fwd = 1; m_dspace = 1; m_daddr = a - 32'hFD000000 + m_mbr;
      end
      if (hit) m_state = fwd ? 1 : 2;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_par = 0; m_mbr = 0; m_iobr = 0; m_rdata = 0; m_rd = 0;
         for (int i = 0; i < 64; i++) m_cfg[i] = 0;
         m_cfg[0] = 32'h350E1054; m_cfg[1] = 32'h02900080;
      end else begin
         case (m_state)
            0: if (cpu_req) model_accept();
            1: if (dn_ack) begin m_state = 2; if (m_rd) m_rdata = dn_rdata; end
            default: m_state = 0;
         endcase
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(cpu_ack === (m_state == 2), "cpu_ack (R9/R10)", 32'(cpu_ack), 32'(m_state == 2));
         check(dn_req === (m_state == 1), "dn_req (R1/R9)", 32'(dn_req), 32'(m_state == 1));
         if (m_state == 1 && dn_req) begin
            check(dn_addr === m_daddr, "dn_addr", dn_addr, m_daddr);
            check(dn_space === m_dspace, "dn_space", 32'(dn_space), 32'(m_dspace));
            check(dn_size === m_dsize, "dn_size", 32'(dn_size), 32'(m_dsize));
            check(dn_we === m_dwe, "dn_we", 32'(dn_we), 32'(m_dwe));
            if (m_dwe) check(dn_wdata === m_dwdata, "dn_wdata", dn_wdata, m_dwdata);
         end
         if (m_state == 2 && m_rd && cpu_ack)
            check(cpu_rdata === m_rdata, "cpu_rdata", cpu_rdata, m_rdata);
      end
   end

   // downstream responder: acknowledge on the third cycle of a request
   int dly = 0;
   always @(negedge clk) begin
      if (dn_ack) begin
         dn_ack = 1'b0;
      end else if (dn_req) begin
         dly++;
         if (dly == 2) begin
            dn_ack   = 1'b1;
            dn_rdata = dn_addr ^ 32'h5A5A0000;
            dly      = 0;
         end
      end
   end

   task automatic cpu_op(input bit we, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd, output bit acked);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 0;
      acked = 0; rd = 0;
      for (int i = 0; i < 12 && !acked; i++) begin
         if (cpu_ack) begin acked = 1; rd = cpu_rdata; end
         else @(negedge clk);
      end
   endtask

   task automatic rd_expect(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] exp);
      logic [31:0] rd; bit ak;
      cpu_op(0, a, sz, 0, rd, ak);
      check(ak, "read acknowledged", 32'(ak), 1);
      check(rd === exp, "read data", rd, exp);
   endtask

   task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      logic [31:0] rd; bit ak;
      cpu_op(1, a, sz, d, rd, ak);
      check(ak, "write acknowledged", 32'(ak), 1);
   endtask

   task automatic unclaimed(input logic [31:0] a);
      logic [31:0] rd; bit ak;
      cpu_op(0, a, 2, 0, rd, ak);
      check(!ak, "unclaimed access acked", 32'(ak), 0);
   endtask

   task automatic summary();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL %s watchdog actual=%h expected=%h", cur_tag, 32'(0), 32'(1));
         summary();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R11 reset state
      cur_tag = "R11";
      check(cpu_ack === 0, "cpu_ack after reset", 32'(cpu_ack), 0);
      check(dn_req === 0, "dn_req after reset", 32'(dn_req), 0);
      rd_expect(32'h1E200008, 2, 32'h0);
      rd_expect(32'hFD000010, 2, 32'h5A5A0010);   // memory base zero after reset
      // R3 preset identity
      cur_tag = "R3";
      rd_expect(32'h1E200000, 2, 32'h350E1054);
      rd_expect(32'h1E200004, 2, 32'h02900080);
      // R2 image words
      cur_tag = "R2";
      wr(32'h1E2000FC, 2, 32'hCAFEF00D);
      rd_expect(32'h1E2000FC, 2, 32'hCAFEF00D);
      wr(32'h1E200040, 2, 32'h01020304);
      rd_expect(32'h1E200040, 2, 32'h01020304);
      // R4 register slots and read-as-zero
      cur_tag = "R4";
      rd_expect(32'h1E200100, 2, 32'h0);
      wr(32'h1E200104, 2, 32'hFFFFFFFF);
      rd_expect(32'h1E200104, 2, 32'h0);
      wr(32'h1E2001C0, 2, 32'h80001234);
      rd_expect(32'h1E2001C0, 2, 32'h80001234);
      wr(32'h1E2001C4, 2, 32'h40000000);
      rd_expect(32'h1E2001C4, 2, 32'h0);
      wr(32'h1E2001C8, 2, 32'h00001000);
      rd_expect(32'h1E2001C8, 2, 32'h0);
      // R5 configuration data port
      cur_tag = "R5";
      wr(32'h1E200220, 2, 32'h11223344);
      rd_expect(32'h1E200220, 2, 32'hDA5A1234);
      // R6 narrow control accesses
      cur_tag = "R6";
      wr(32'h1E2000FC, 0, 32'h000000AA);
      rd_expect(32'h1E2000FC, 2, 32'hCAFEF00D);
      rd_expect(32'h1E200000, 1, 32'h0);
      wr(32'h1E2001C0, 1, 32'h0000FFFF);
      rd_expect(32'h1E2001C0, 2, 32'h80001234);
      // R7 memory window ends
      cur_tag = "R7";
      rd_expect(32'hFD000000, 0, 32'h1A5A0000);
      rd_expect(32'hFDFFFFFF, 0, 32'h1AA5FFFF);
      wr(32'hFD000002, 1, 32'h0000BEEF);
      // R8 I/O window ends
      cur_tag = "R8";
      rd_expect(32'h1E240000, 0, 32'h5A5A1000);
      rd_expect(32'h1E27FFFF, 2, 32'h5A5E0FFF);
      wr(32'h1E240010, 1, 32'h00001234);
      // R1 addresses just outside each window
      cur_tag = "R1";
      unclaimed(32'hFCFFFFFF);
      unclaimed(32'hFE000000);
      unclaimed(32'h1E200224);
      unclaimed(32'h1E23FFFF);
      unclaimed(32'h1E280000);
      unclaimed(32'h1E1FFFFC);
      // R9 request arriving together with the downstream acknowledge
      cur_tag = "R9";
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = 32'hFD000100; cpu_size = 2;
      @(negedge clk);
      cpu_req = 0;
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = 32'h1E2001C0; cpu_wdata = 32'h0BADBEEF;
      @(negedge clk);
      cpu_req = 0;
      check(cpu_ack === 1, "ack after dn_ack", 32'(cpu_ack), 1);
      check(cpu_rdata === 32'h1A5A0100, "forwarded read data", cpu_rdata, 32'h1A5A0100);
      repeat (2) @(negedge clk);
      rd_expect(32'h1E2001C0, 2, 32'h80001234);
      repeat (3) @(negedge clk);
      summary();
   end

endmodule